// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs transfers on an external bus where one set of pins carries first the address and then the data. A transfer opens with an address phase. The controller drives the address onto the shared pins and raises an address latch strobe, so that external logic can capture and de-multiplex it. In the data phase that follows, the controller either releases the pins and raises a read strobe, or drives the write data and raises a write strobe. The transfer ends when the external side raises its ready input. The ready input may stay low for any number of cycles, which inserts wait states.

The block runs from a clock at twice the bus rate, so one clock of this block is half a bus clock. The address strobe lasts `ALE_TICKS` clocks. When the extended-hold input is high at acceptance, one extra clock is added after the strobe falls. During that clock the address stays on the pins, which gives slow latches more hold time.

The internal side offers one request at a time with a valid/ready pair. It reports each completed transfer with a single-cycle done pulse and, for reads, the captured data.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset, `ale`, `ad_oe`, `rd_stb`, `wr_stb` and `rsp_done` are low, `ad_out` is zero and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until the cycle after completion. A `req_valid` raised while `req_ready` is low is ignored and starts no transfer.
- R3: For the `ALE_TICKS` cycles after acceptance, `ale` is high, `ad_oe` is high and `ad_out` carries the request address, zero-extended to `BUS_W`.
- R4: `ext_hold` is sampled only at acceptance. If it was 1, one cycle follows the address phase with `ale` low, `ad_oe` high and `ad_out` still equal to the address. If it was 0, the data phase starts right after the address phase.
- R5: In a read data phase (`req_write` was 0 at acceptance), `ad_oe` is low and `rd_stb` is high. Both hold until `bus_rdy` is sampled high.
- R6: In a write data phase (`req_write` was 1), `ad_oe` is high, `ad_out` equals the write data and `wr_stb` is high. All three hold until `bus_rdy` is sampled high.
- R7: While `bus_rdy` is low, the data phase continues for any number of cycles and the pin outputs do not change.
- R8: In the cycle after `bus_rdy` is sampled high, `rsp_done` is high for exactly one cycle. For a read, `rsp_rdata` equals `ad_in` as sampled at that edge. A write leaves `rsp_rdata` unchanged.
- R9: In the cycle after completion, `ale`, `ad_oe`, `rd_stb` and `wr_stb` are all low. So at least one released cycle separates any transfer from the next address phase.
- R10: At most one of `ale`, `rd_stb` and `wr_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | BUS_W | Write data |
| ext_hold | input | 1 | Add one address-hold cycle after the strobe falls |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | BUS_W | Last captured read data |
| ale | output | 1 | Address latch strobe |
| ad_out | output | BUS_W | Value driven on the shared pins |
| ad_oe | output | 1 | Output enable of the shared pins |
| ad_in | input | BUS_W | Value seen on the shared pins |
| rd_stb | output | 1 | Read data phase strobe |
| wr_stb | output | 1 | Write data phase strobe |
| bus_rdy | input | 1 | External ready, ends the data phase |

## Verification
The assertions assume that `bus_rdy` is only considered inside a data phase. They also assume that the request fields matter only in the cycle of acceptance. The bench therefore drives `bus_rdy` high only in the one data-phase cycle that should end the transfer, and lowers it again at once. It also deliberately changes the address, data and `ext_hold` right after acceptance, and raises `req_valid` during wait states. This shows that none of these inputs affect a transfer already in flight.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_HOLD = 2'd2,
      PH_DATA = 2'd3
   } phase_e;
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
   import mbc_pkg::*;
#(
   parameter int ALE_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic ext_hold,
   input  logic bus_rdy,
   output logic req_ready,
   output logic accept,
   output logic ale,
   output logic drive_addr,
   output logic drive_data,
   output logic rd_stb,
   output logic wr_stb,
   output logic done,
   output logic is_write
);
   phase_e phase_q;
   logic   wr_q;
   logic   hold_q;
   logic   addr_last;

   // strobe length variant: single tick needs no counter
   generate
      if (ALE_TICKS == 1) begin : g_one
         assign addr_last = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(ALE_TICKS);
         localparam logic [CW-1:0] LAST = CW'(ALE_TICKS - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (phase_q == PH_ADDR && cnt_q != LAST)
               cnt_q <= cnt_q + 1'b1;
            else
               cnt_q <= '0;
         end
         assign addr_last = (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wr_q    <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: if (req_valid) begin
               phase_q <= PH_ADDR;
               wr_q    <= req_write;
               hold_q  <= ext_hold;
            end
            PH_ADDR: if (addr_last) phase_q <= hold_q ? PH_HOLD : PH_DATA;
            PH_HOLD: phase_q <= PH_DATA;
            PH_DATA: if (bus_rdy) phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign req_ready  = (phase_q == PH_IDLE);
   assign accept     = req_ready && req_valid;
   assign ale        = (phase_q == PH_ADDR);
   assign drive_addr = (phase_q == PH_ADDR) || (phase_q == PH_HOLD);
   assign drive_data = (phase_q == PH_DATA) && wr_q;
   assign rd_stb     = (phase_q == PH_DATA) && !wr_q;
   assign wr_stb     = (phase_q == PH_DATA) && wr_q;
   assign done       = (phase_q == PH_DATA) && bus_rdy;
   assign is_write   = wr_q;

   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ale, rd_stb, wr_stb}));
   p_rd_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !bus_rdy) |=> rd_stb);
   p_wr_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !bus_rdy) |=> wr_stb);
   p_accept_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (ale && !req_ready));
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (req_ready && !ale && !rd_stb && !wr_stb));
   p_hold_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HOLD) |-> ($past(phase_q) == PH_ADDR && hold_q));
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins #(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  req_wdata,
   input  logic              ale,
   input  logic              drive_addr,
   input  logic              drive_data,
   output logic [BUS_W-1:0]  ad_out,
   output logic              ad_oe
);
   logic [BUS_W-1:0] addr_q;
   logic [BUS_W-1:0] wdata_q;
   logic [BUS_W-1:0] addr_ext;

   // address width variant: pad narrower addresses with zeros
   generate
      if (ADDR_W == BUS_W) begin : g_full
         assign addr_ext = req_addr;
      end else begin : g_pad
         assign addr_ext = {{(BUS_W - ADDR_W){1'b0}}, req_addr};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= addr_ext;
         wdata_q <= req_wdata;
      end
   end

   always_comb begin
      if (drive_addr)      ad_out = addr_q;
      else if (drive_data) ad_out = wdata_q;
      else                 ad_out = '0;
   end
   assign ad_oe = drive_addr || drive_data;

   p_addr_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> ad_oe);
   p_addr_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_addr && !ale && $past(ale)) |-> $stable(ad_out));
   p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_data && $past(drive_data)) |-> $stable(ad_out));
endmodule

// File: rtl/mbc_capture.sv
module mbc_capture #(
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             is_write,
   input  logic [BUS_W-1:0] ad_in,
   output logic             rsp_done,
   output logic [BUS_W-1:0] rsp_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done <= done;
         if (done && !is_write) rsp_rdata <= ad_in;
      end
   end

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   p_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && is_write) |-> $stable(rsp_rdata));
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
   parameter int BUS_W     = 32,
   parameter int ADDR_W    = 32,
   parameter int ALE_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  req_wdata,
   input  logic              ext_hold,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [BUS_W-1:0]  rsp_rdata,
   output logic              ale,
   output logic [BUS_W-1:0]  ad_out,
   output logic              ad_oe,
   input  logic [BUS_W-1:0]  ad_in,
   output logic              rd_stb,
   output logic              wr_stb,
   input  logic              bus_rdy
);
   generate
      if (BUS_W < 8 || BUS_W > 64) begin : g_bad_bus
         $error("BUS_W must lie in 8..64");
      end
      if (ADDR_W < 1 || ADDR_W > BUS_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..BUS_W");
      end
      if (ALE_TICKS < 1 || ALE_TICKS > 16) begin : g_bad_ale
         $error("ALE_TICKS must lie in 1..16");
      end
   endgenerate

   logic accept, drive_addr, drive_data, done, is_write;

   mbc_seq #(.ALE_TICKS(ALE_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .ext_hold(ext_hold), .bus_rdy(bus_rdy), .req_ready(req_ready),
      .accept(accept), .ale(ale), .drive_addr(drive_addr),
      .drive_data(drive_data), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .done(done), .is_write(is_write)
   );

   mbc_pins #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_pins (
      .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
      .req_wdata(req_wdata), .ale(ale), .drive_addr(drive_addr),
      .drive_data(drive_data), .ad_out(ad_out), .ad_oe(ad_oe)
   );

   mbc_capture #(.BUS_W(BUS_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .done(done), .is_write(is_write),
      .ad_in(ad_in), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> !ad_oe);
   p_wr_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ad_oe);
endmodule

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb;
   localparam int BW  = 32;
   localparam int ALE = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_write, ext_hold, bus_rdy;
   logic [BW-1:0] req_addr, req_wdata, ad_in;
   logic          req_ready, rsp_done, ale, ad_oe, rd_stb, wr_stb;
   logic [BW-1:0] rsp_rdata, ad_out;

   int checks = 0;
   int errors = 0;
   logic [BW-1:0] last_rd = '0;

   always #2.5 clk = ~clk;

   mux_bus_ctrl #(.BUS_W(BW), .ADDR_W(BW), .ALE_TICKS(ALE)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ext_hold(ext_hold),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_rdy(bus_rdy)
   );

   task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; req_valid = 0; req_write = 0; ext_hold = 0; bus_rdy = 0;
      req_addr = '0; req_wdata = '0; ad_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ale", ale, 0);
      chk("R1 ad_oe", ad_oe, 0);
      chk("R1 rd_stb", rd_stb, 0);
      chk("R1 wr_stb", wr_stb, 0);
      chk("R1 rsp_done", rsp_done, 0);
      chk("R1 ad_out", ad_out, 0);
      chk("R1 req_ready", req_ready, 1);
   endtask

   task automatic xfer(input bit wr, input logic [BW-1:0] addr, input logic [BW-1:0] wd,
                       input bit hold, input int waits, input logic [BW-1:0] rd, input bit poke);
      chk("R2 ready when idle", req_ready, 1);
      req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd; ext_hold = hold;
      @(negedge clk);
      req_valid = 0; req_addr = ~addr; req_wdata = ~wd; ext_hold = ~hold;
      for (int a = 0; a < ALE; a++) begin
         if (a > 0) @(negedge clk);
         chk("R3 ale high", ale, 1);
         chk("R3 ad_oe", ad_oe, 1);
         chk("R3 address on pins", ad_out, addr);
         chk("R2 busy", req_ready, 0);
      end
      if (hold) begin
         @(negedge clk);
         chk("R4 ale low in hold", ale, 0);
         chk("R4 ad_oe in hold", ad_oe, 1);
         chk("R4 address held", ad_out, addr);
         chk("R4 no strobe in hold", {rd_stb, wr_stb}, 0);
      end
      @(negedge clk);
      for (int i = 0; i <= waits; i++) begin
         if (i > 0) @(negedge clk);
         chk(i > 0 ? "R7 ale low in wait" : "R4 ale low in data", ale, 0);
         if (wr) begin
            chk("R6 wr_stb", wr_stb, 1);
            chk("R10 rd_stb off", rd_stb, 0);
            chk("R6 ad_oe", ad_oe, 1);
            chk(i > 0 ? "R7 wdata stable" : "R6 wdata on pins", ad_out, wd);
         end else begin
            chk("R5 rd_stb", rd_stb, 1);
            chk("R10 wr_stb off", wr_stb, 0);
            chk(i > 0 ? "R7 pins released" : "R5 pins released", ad_oe, 0);
         end
         if (poke && i == 0) begin
            req_valid = 1; req_addr = 32'h5A5A_0000;
         end
         if (poke && i == 1) begin
            chk("R2 ready low while busy", req_ready, 0);
            req_valid = 0;
         end
         bus_rdy = (i == waits);
         ad_in = (i == waits) ? rd : (32'hBAD0_0000 | BW'(i));
      end
      @(negedge clk);
      bus_rdy = 0; ad_in = 32'hFFFF_0000;
      chk("R8 rsp_done", rsp_done, 1);
      chk(wr ? "R8 write keeps rdata" : "R8 read data", rsp_rdata, wr ? last_rd : rd);
      if (!wr) last_rd = rd;
      chk("R9 ad_oe released", ad_oe, 0);
      chk("R9 ale low", ale, 0);
      chk("R9 strobes low", {rd_stb, wr_stb}, 0);
      chk("R2 ready after done", req_ready, 1);
      @(negedge clk);
      chk("R8 done single pulse", rsp_done, 0);
      chk("R2 no queued transfer", ale, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      xfer(1'b0, 32'h1000_0040, 32'h0,         1'b0, 0, 32'hCAFE_0001, 1'b0);
      xfer(1'b1, 32'h2000_0080, 32'h1234_5678, 1'b0, 0, 32'h0,         1'b0);
      xfer(1'b0, 32'h3000_00C0, 32'h0,         1'b1, 3, 32'hBEEF_0002, 1'b0);
      xfer(1'b1, 32'h4000_0100, 32'h8765_4321, 1'b1, 5, 32'h0,         1'b1);
      xfer(1'b0, 32'hFFFF_FFFC, 32'h0,         1'b0, 2, 32'h0F0F_F0F0, 1'b1);
      xfer(1'b1, 32'h0000_0004, 32'hA5A5_A5A5, 1'b0, 1, 32'h0,         1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule